// File: doc/BRIEF.md
# Compressed-Audio Burst Sync Detector

This block sits behind an IEC60958 receiver's subframe decoder. It takes one audio word per subframe, together with a strobe that marks the first subframe of each frame. It looks in that stream for the 96-bit sync that opens a 32-bit mode non-PCM burst. When it finds the sync, it raises a sticky detect flag. It then latches the two burst-information words that come after the sync: first the data-type word, then the length word.

The flag stays high while bursts keep arriving. It drops once 4096 frames have passed with no fresh sync. A second, independent matcher looks for a sync pattern set by parameters, meant for an alternate compressed bitstream. It drives its own flag, which expires on the same timeout.

The input is a valid/ready stream. `in_ready` is always high, so the block never applies back-pressure. A word counts only in a cycle where `in_valid` is high, and a word offered in that cycle is taken in that cycle. The flags and the burst words are plain level outputs.

Top module: `nonpcm_burst_detect`

## Requirements
- R1: `in_ready` is always 1. Only words accepted with `in_valid`=1 are matched, counted or captured. Matching uses `in_word[23:8]`. A cycle with `in_valid`=0 has no effect, whatever data is on the input.
- R2: The accepted sequence 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F sets `nonpcm_det` to 1. The flag is visible in the cycle after the last sync word is accepted.
- R3: A 16-bit mode preamble does not set `nonpcm_det`. Such a preamble is 0xF872 followed by 0x4E1F with fewer than four 0x0000 words before it.
- R4: A mismatch partway through the sequence restarts matching. A mismatching 0x0000 counts as a new first word. Extra leading 0x0000 words beyond four keep the match alive.
- R5: After each primary detection, the next accepted word is latched into `burst_pc` and the one after it into `burst_pd`. Each register updates in the cycle after its word is accepted.
- R6: Once set, `nonpcm_det` stays at 1 until the 4096th frame strobe accepted after the last detection. It reads 0 in the cycle after that strobe. A strobe that arrives with a detecting word does not count.
- R7: Each new detection restarts the 4096-frame window.
- R8: `alt_det` follows R2, R4, R6 and R7 for the parameter pattern. Its default is 0x1FFF, 0xE800, 0x07F1.
- R9: A synchronous active-low `rst_n` clears both flags, both frame counters, both match positions, `burst_pc` and `burst_pd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Subframe word offered |
| in_ready | output | 1 | Always 1; the block never stalls |
| in_word | input | 24 | Subframe audio slot; bits 23:8 are matched |
| in_frame | input | 1 | Word is the first subframe of a frame |
| nonpcm_det | output | 1 | 32-bit mode non-PCM burst sync seen recently |
| alt_det | output | 1 | Alternate-stream sync seen recently |
| burst_pc | output | 16 | First word after the last primary sync |
| burst_pd | output | 16 | Second word after the last primary sync |

## Verification
Every result comes from one register stage behind the accepting edge. A flag that a sync word sets, a flag that the final frame strobe clears, and a captured burst word all appear in the cycle after their word is accepted. The bench drives each word before a rising edge and reads the outputs 1 ns after that edge, so each check falls in the first cycle where the result is due. The timeout checks count frame strobes exactly, reading the flag after the 4095th strobe and again after the 4096th.

// File: rtl/nbd_pkg.sv
package nbd_pkg;
  localparam int SYNC_W = 16;
  localparam int SLOT_W = 24;
  localparam int PRI_LEN = 6;
  localparam logic [PRI_LEN*SYNC_W-1:0] PRI_PAT =
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 16'hF872, 16'h4E1F};
  localparam int ALT_LEN_DEF = 3;
  localparam logic [ALT_LEN_DEF*SYNC_W-1:0] ALT_PAT_DEF =
    {16'h1FFF, 16'hE800, 16'h07F1};
  localparam int TIMEOUT_DEF = 4096;

  typedef enum logic [1:0] {CAP_IDLE, CAP_PC, CAP_PD} cap_state_e;
endpackage

// File: rtl/nbd_seq_matcher.sv
module nbd_seq_matcher #(
  parameter int LEN = 6,
  parameter logic [LEN*nbd_pkg::SYNC_W-1:0] PAT = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      take,
  input  logic [nbd_pkg::SYNC_W-1:0] word,
  output logic                      hit
);
  localparam int W = nbd_pkg::SYNC_W;
  localparam int IW = (LEN > 2) ? $clog2(LEN) : 1;

  function automatic int lead_run();
    int n = 1;
    for (int i = 1; i < LEN; i++)
      if (n == i && PAT[(LEN-1-i)*W +: W] == PAT[(LEN-1)*W +: W]) n = i + 1;
    return n;
  endfunction

  localparam int LEAD = lead_run();
  localparam logic [W-1:0] FIRST = PAT[(LEN-1)*W +: W];

  logic [IW-1:0] idx, idx_n;
  logic [W-1:0]  expect_w;

  always_comb begin
    expect_w = PAT[(LEN-1-int'(idx))*W +: W];
    idx_n = idx;
    hit = 1'b0;
    if (take) begin
      if (word == expect_w) begin
        if (int'(idx) == LEN-1) begin
          idx_n = '0;
          hit = 1'b1;
        end else begin
          idx_n = idx + 1'b1;
        end
      end else if (word == FIRST) begin
        idx_n = (int'(idx) == LEAD) ? IW'(LEAD) : IW'(1);
      end else begin
        idx_n = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idx <= '0;
    else        idx <= idx_n;
  end

  assert_idx_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) < LEN);
endmodule

// File: rtl/nbd_hold_timer.sv
module nbd_hold_timer #(
  parameter int TIMEOUT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic tick,
  output logic flag
);
  localparam int CW = $clog2(TIMEOUT + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag <= 1'b0;
      cnt  <= '0;
    end else if (hit) begin
      flag <= 1'b1;
      cnt  <= '0;
    end else if (flag && tick) begin
      if (cnt == CW'(TIMEOUT - 1)) begin
        flag <= 1'b0;
        cnt  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assert_rise_after_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
  assert_fall_at_window_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(tick && cnt == CW'(TIMEOUT - 1)));
  assert_idle_count_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !flag |-> cnt == '0);
endmodule

// File: rtl/nbd_burst_capture.sv
module nbd_burst_capture (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       take,
  input  logic                       hit,
  input  logic [nbd_pkg::SYNC_W-1:0] word,
  output logic [nbd_pkg::SYNC_W-1:0] pc,
  output logic [nbd_pkg::SYNC_W-1:0] pd
);
  import nbd_pkg::*;
  cap_state_e state;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= CAP_IDLE;
      pc    <= '0;
      pd    <= '0;
    end else if (take) begin
      if (hit) begin
        state <= CAP_PC;
      end else begin
        case (state)
          CAP_PC: begin pc <= word; state <= CAP_PD; end
          CAP_PD: begin pd <= word; state <= CAP_IDLE; end
          default: state <= CAP_IDLE;
        endcase
      end
    end
  end

  assert_pc_load_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pc) |-> $past(state == CAP_PC && take));
  assert_pd_load_slot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd) |-> $past(state == CAP_PD && take));
endmodule

// File: rtl/nonpcm_burst_detect.sv
module nonpcm_burst_detect #(
  parameter int TIMEOUT = nbd_pkg::TIMEOUT_DEF,
  parameter int ALT_LEN = nbd_pkg::ALT_LEN_DEF,
  parameter logic [ALT_LEN*nbd_pkg::SYNC_W-1:0] ALT_PAT = nbd_pkg::ALT_PAT_DEF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [23:0] in_word,
  input  logic        in_frame,
  output logic        nonpcm_det,
  output logic        alt_det,
  output logic [15:0] burst_pc,
  output logic [15:0] burst_pd
);
  import nbd_pkg::*;

  logic              take, tick, pri_hit, alt_hit;
  logic [SYNC_W-1:0] sw;
  logic [SLOT_W-SYNC_W-1:0] unused_low;

  assign in_ready   = 1'b1;
  assign take       = in_valid;
  assign tick       = in_valid && in_frame;
  assign sw         = in_word[SLOT_W-1 -: SYNC_W];
  assign unused_low = in_word[SLOT_W-SYNC_W-1:0];

  nbd_seq_matcher #(.LEN(PRI_LEN), .PAT(PRI_PAT)) u_pri_match (
    .clk(clk), .rst_n(rst_n), .take(take), .word(sw), .hit(pri_hit));

  nbd_seq_matcher #(.LEN(ALT_LEN), .PAT(ALT_PAT)) u_alt_match (
    .clk(clk), .rst_n(rst_n), .take(take), .word(sw), .hit(alt_hit));

  nbd_hold_timer #(.TIMEOUT(TIMEOUT)) u_pri_timer (
    .clk(clk), .rst_n(rst_n), .hit(pri_hit), .tick(tick), .flag(nonpcm_det));

  nbd_hold_timer #(.TIMEOUT(TIMEOUT)) u_alt_timer (
    .clk(clk), .rst_n(rst_n), .hit(alt_hit), .tick(tick), .flag(alt_det));

  nbd_burst_capture u_capture (
    .clk(clk), .rst_n(rst_n), .take(take), .hit(pri_hit), .word(sw),
    .pc(burst_pc), .pd(burst_pd));
endmodule

// File: tb/test_nonpcm_burst_detect.sv
`timescale 1ns/1ps
module test_nonpcm_burst_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [23:0] in_word = '0;
  logic        in_frame = 1'b0;
  logic        nonpcm_det, alt_det;
  logic [15:0] burst_pc, burst_pd;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  nonpcm_burst_detect i_nonpcm_burst_detect (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_frame(in_frame), .nonpcm_det(nonpcm_det),
    .alt_det(alt_det), .burst_pc(burst_pc), .burst_pd(burst_pd));

  // {frame, expected nonpcm_det, expected alt_det, word}
  localparam int NV = 13;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b0, 16'h0000}, {1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b0, 1'b0, 16'h0000}, {1'b0, 1'b0, 1'b0, 16'h0000},
    {1'b1, 1'b0, 1'b0, 16'hF872}, {1'b0, 1'b1, 1'b0, 16'h4E1F},
    {1'b1, 1'b1, 1'b0, 16'h0011}, {1'b0, 1'b1, 1'b0, 16'h0022},
    {1'b1, 1'b1, 1'b0, 16'h1FFF}, {1'b0, 1'b1, 1'b0, 16'hE800},
    {1'b1, 1'b1, 1'b1, 16'h07F1}, {1'b0, 1'b1, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b1, 16'hABCD}};

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(logic [15:0] w, logic frm);
    in_valid = 1'b1;
    in_word  = {w, 8'h5A};
    in_frame = frm;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_frame = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk); @(posedge clk);
    #1;
    rst_n = 1'b1;
  endtask

  task automatic pri_sync();
    for (int i = 0; i < 4; i++) send(16'h0000, 1'b0);
    send(16'hF872, 1'b0);
    send(16'h4E1F, 1'b0);
  endtask

  task automatic frames(int n);
    for (int f = 0; f < n; f++) begin
      send(16'h1234, 1'b1);
      send(16'h1234, 1'b0);
    end
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R9 reset nonpcm", 32'(nonpcm_det), 0);
    check("R9 reset alt", 32'(alt_det), 0);
    check("R1 ready", 32'(in_ready), 1);

    for (int v = 0; v < NV; v++) begin
      send(VEC[v][15:0], VEC[v][18]);
      check("R2 table nonpcm", 32'(nonpcm_det), 32'(VEC[v][17]));
      check("R8 table alt", 32'(alt_det), 32'(VEC[v][16]));
    end
    check("R5 pc", 32'(burst_pc), 32'h0011);
    check("R5 pd", 32'(burst_pd), 32'h0022);

    do_reset();
    check("R9 pc cleared", 32'(burst_pc), 0);
    check("R9 flags cleared", {nonpcm_det, alt_det}, 0);

    // R3: 16-bit mode preambles
    send(16'h0000, 1'b0); send(16'hF872, 1'b0); send(16'h4E1F, 1'b0);
    check("R3 short prefix", 32'(nonpcm_det), 0);
    send(16'hF872, 1'b0); send(16'h4E1F, 1'b0);
    check("R3 bare preamble", 32'(nonpcm_det), 0);
    for (int i = 0; i < 3; i++) send(16'h0000, 1'b0);
    send(16'hF872, 1'b0); send(16'h4E1F, 1'b0);
    check("R3 three zeros", 32'(nonpcm_det), 0);

    // R4: restart and surplus zeros
    send(16'h0000, 1'b0); send(16'h0000, 1'b0); send(16'h5555, 1'b0);
    for (int i = 0; i < 5; i++) send(16'h0000, 1'b0);
    send(16'hF872, 1'b0);
    check("R4 not yet", 32'(nonpcm_det), 0);
    send(16'h4E1F, 1'b0);
    check("R4 restart detect", 32'(nonpcm_det), 1);

    // R1/R5: capture with an idle gap carrying junk
    send(16'hAAAA, 1'b0);
    check("R5 pc latched", 32'(burst_pc), 32'hAAAA);
    in_word = {16'h9999, 8'h00};
    in_frame = 1'b1;
    @(posedge clk); #1;
    in_frame = 1'b0;
    check("R1 gap pd unchanged", 32'(burst_pd), 0);
    check("R1 gap pc unchanged", 32'(burst_pc), 32'hAAAA);
    send(16'hBBBB, 1'b0);
    check("R5 pd latched", 32'(burst_pd), 32'hBBBB);

    // R6/R8: timeout of both flags
    do_reset();
    pri_sync();
    send(16'h1FFF, 1'b0); send(16'hE800, 1'b0); send(16'h07F1, 1'b0);
    check("R8 alt set", 32'(alt_det), 1);
    frames(4095);
    check("R6 held at 4095", 32'(nonpcm_det), 1);
    check("R8 held at 4095", 32'(alt_det), 1);
    send(16'h1234, 1'b1);
    check("R6 cleared at 4096", 32'(nonpcm_det), 0);
    check("R8 cleared at 4096", 32'(alt_det), 0);

    // R7: reload
    do_reset();
    pri_sync();
    frames(3000);
    pri_sync();
    frames(3000);
    check("R7 held after reload", 32'(nonpcm_det), 1);
    frames(1095);
    check("R7 held at 4095", 32'(nonpcm_det), 1);
    send(16'h1234, 1'b1);
    check("R7 cleared at 4096", 32'(nonpcm_det), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule